// File: doc/BRIEF.md
# Bus Snapshot Serial Transmitter

This block sends a snapshot of the sixteen bytes that the display scan walks through to a host computer over an asynchronous serial line. An external scan counter supplies the index of the byte now on the internal bus. That counter is clocked by a further divide-by-sixteen stage above the bit clock, so each index lasts sixteen bit periods. A byte frame is ten bit periods long, so one byte can be sent inside every index slot. The bit clock itself comes from the oscillator divided by sixteen. With a 1.8432 MHz oscillator that gives 115200 bit/s, and the packet rate stays below 720 per second.

A dump request is held until the scan index next moves to zero. From that point, each byte is captured as its index appears and is shifted out as an 8N1 frame. The line rests high, the start bit is low, the data goes least significant bit first and the stop bit is high. Sixteen frames, one per index, form one packet. A request that arrives during a packet is held and served by the packet that starts at the next wrap. A busy flag covers the whole time from the request to the end of the last stop bit.

Top module: `snap_tx`

## Requirements
- R1: While reset is low, and on the first cycle after it, tx_o is 1 and busy_o is 0.
- R2: Every frame has the same layout and timing. A start bit of 0 comes first, then DATA_W data bits with bit 0 first, then a stop bit of 1. Each bit lasts exactly one bit period, and tx_o changes only on a clock edge where bit_en_i is 1.
- R3: If no dump request is made, no frame is sent and tx_o stays at 1.
- R4: A dump request starts a packet when scan_idx_i next moves to 0. The packet has one frame per index, in order 0, 1, ... 2^IDX_W-1, and each frame carries byte_i as sampled on the cycle its index first appears. A request seen on the very cycle of the move to 0 starts the packet there.
- R5: The start bit of each frame begins on the first bit_en_i pulse after the pulse that goes with the index change.
- R6: A dump request made while a packet is running is held, and a second packet follows at the next move of the index to 0.
- R7: Several requests made before a packet starts cause exactly one packet.
- R8: A request that comes after the index has already moved to 0 waits a full scan, until the next move to 0.
- R9: busy_o is 1 from the cycle after a request until the bit_en_i pulse that ends the stop bit of the packet's last frame, and 0 after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-cycle pulse per serial bit period |
| byte_i | input | DATA_W | Bus byte selected by the current scan index |
| dump_req_i | input | 1 | Request to send one packet |
| scan_idx_i | input | IDX_W | Shared scan index; it advances once every 16 bit periods |
| tx_o | output | 1 | Serial output; 1 when idle |
| busy_o | output | 1 | A request is pending or a packet is being sent |

## Verification
The bench uses the default widths: 8-bit bytes and a 4-bit index, which gives 16-byte packets. It drives a bit-rate pulse on every fourth clock and advances the index once every sixteen pulses. One scan is therefore about a thousand clocks. This keeps within reach the cases that need several scans: back-to-back packets, requests that merge into one packet, a request that has to wait a whole scan, and the exact pulse on which busy drops. A bench-side receiver samples the line once per bit period and records where each start bit falls within its index slot.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  localparam logic START_BIT = 1'b0;
  localparam logic STOP_BIT  = 1'b1;
endpackage

// File: rtl/snap_seq.sv
module snap_seq
  import snap_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dump_req_i,
  input  logic [IDX_W-1:0] scan_idx_i,
  output logic             load_o,
  output logic             active_o
);
  localparam logic [IDX_W-1:0] IDX_FIRST = '0;
  localparam logic [IDX_W-1:0] IDX_LAST  = {IDX_W{1'b1}};

  seq_state_e       state_q, state_d;
  logic             again_q, again_d;
  logic [IDX_W-1:0] idx_q;
  logic             slot_new, at_first, at_last;

  assign slot_new = (scan_idx_i != idx_q);
  assign at_first = slot_new && (scan_idx_i == IDX_FIRST);
  assign at_last  = slot_new && (scan_idx_i == IDX_LAST);

  always_comb begin
    state_d = state_q;
    again_d = again_q;
    load_o  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (dump_req_i) begin
          if (at_first) begin
            state_d = SEQ_RUN;
            load_o  = 1'b1;
          end else begin
            state_d = SEQ_ARMED;
          end
        end
      end
      SEQ_ARMED: begin
        if (at_first) begin
          state_d = SEQ_RUN;
          load_o  = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (dump_req_i) again_d = 1'b1;
        if (slot_new) load_o = 1'b1;
        if (at_last) begin
          state_d = again_d ? SEQ_ARMED : SEQ_IDLE;
          again_d = 1'b0;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      again_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      again_q <= again_d;
      idx_q   <= scan_idx_i;
    end
  end

  assign active_o = (state_q != SEQ_IDLE);

  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RUN && $past(state_q) != SEQ_RUN) |-> ($past(scan_idx_i) == IDX_FIRST)); // R4
  AST_ONE_LOAD_PER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R4
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RUN && dump_req_i) |=> (again_q || state_q == SEQ_ARMED)); // R6
endmodule

// File: rtl/snap_shift.sv
module snap_shift
  import snap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              staged_q;
  logic [DATA_W-1:0] hold_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= 1'b0;
      hold_q   <= '0;
      sh_q     <= '1;
      cnt_q    <= '0;
    end else begin
      if (bit_en_i) begin
        if (cnt_q != '0) begin
          sh_q  <= {STOP_BIT, sh_q[FRAME_W-1:1]};
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (staged_q) begin
          sh_q     <= {STOP_BIT, hold_q, START_BIT};
          cnt_q    <= CNT_W'(FRAME_W);
          staged_q <= 1'b0;
        end
      end
      // a fresh load wins over the hand-off in the same cycle
      if (load_i) begin
        staged_q <= 1'b1;
        hold_q   <= byte_i;
      end
    end
  end

  assign tx_o   = (cnt_q != '0) ? sh_q[0] : STOP_BIT;
  assign busy_o = staged_q || (cnt_q != '0);

  AST_SHIFT_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> $past(bit_en_i)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W)); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !staged_q); // R5
endmodule

// File: rtl/snap_tx.sv
module snap_tx #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              dump_req_i,
  input  logic [IDX_W-1:0]  scan_idx_i,
  output logic              tx_o,
  output logic              busy_o
);
  logic load, seq_active, shift_busy;

  snap_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dump_req_i (dump_req_i),
    .scan_idx_i (scan_idx_i),
    .load_o     (load),
    .active_o   (seq_active)
  );

  snap_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .load_i   (load),
    .byte_i   (byte_i),
    .tx_o     (tx_o),
    .busy_o   (shift_busy)
  );

  assign busy_o = seq_active || shift_busy;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R3
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_req_i |=> busy_o); // R9
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_o && !busy_o)); // R1
endmodule

// File: tb/snap_tx_test.sv
module snap_tx_test;
  localparam int BIT_DIV = 4;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] byte_v = 8'h00;
  logic       dump_req = 1'b0;
  logic [3:0] idx = 4'd0;
  logic       tx, busy;

  int tests = 0, fails = 0;
  logic [7:0] seed = 8'h00;

  // receiver state, written only by the generator loop
  logic       rx_busy = 1'b0;
  int         rx_nb = 0, rx_cnt = 0, pos_err = 0, stop_err = 0, starts = 0;
  logic [7:0] rx_sh = 8'h00;
  logic [7:0] rx_buf [256];

  always #10 clk = ~clk;

  snap_tx #(.DATA_W(8), .IDX_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .byte_i(byte_v),
    .dump_req_i(dump_req), .scan_idx_i(idx), .tx_o(tx), .busy_o(busy)
  );

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 29 + int'(s)) ^ 8'hA5;
  endfunction

  // stimulus generator and line receiver, both on the falling edge
  int div = 0, bc = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bit_en) begin
        if (!rx_busy) begin
          if (tx == 1'b0) begin
            rx_busy = 1'b1; rx_nb = 0; starts++;
            if (bc != 1) pos_err++;
          end
        end else if (rx_nb < 8) begin
          rx_sh[rx_nb] = tx; rx_nb++;
        end else begin
          if (tx != 1'b1) stop_err++;
          rx_buf[rx_cnt % 256] = rx_sh; rx_cnt++; rx_busy = 1'b0;
        end
      end
      div = (div + 1) % BIT_DIV;
      bit_en = (div == 0);
      if (bit_en) begin
        bc = (bc + 1) % 16;
        if (bc == 0) idx = idx + 4'd1;
      end
      byte_v = pat(int'(idx), seed);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_enter(input logic [3:0] v);
    logic [3:0] p;
    p = idx;
    forever begin
      step();
      if (idx == v && p != v) break;
      p = idx;
    end
  endtask

  task automatic pulse_req();
    dump_req = 1'b1; step(); dump_req = 1'b0;
  endtask

  task automatic check_packet(input int base, input logic [7:0] s, input string tag);
    for (int i = 0; i < NB; i++)
      chk(rx_buf[(base + i) % 256] == pat(i, s), tag, rx_buf[(base + i) % 256], pat(i, s));
  endtask

  task automatic t_reset();
    step();
    chk(tx == 1'b1, "R1 tx in reset", tx, 1);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    step();
    chk(tx == 1'b1, "R1 tx after reset", tx, 1);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_idle();
    int s0;
    s0 = starts;
    wait_enter(4'd0); wait_enter(4'd0); wait_enter(4'd8);
    chk(starts == s0, "R3 no frame without request", starts - s0, 0);
    chk(tx == 1'b1 && busy == 1'b0, "R3 line idle", {tx, busy}, 2);
  endtask

  task automatic t_single();
    int base, pe, se;
    bit dropped;
    seed = 8'h11; base = rx_cnt; pe = pos_err; se = stop_err; dropped = 0;
    wait_enter(4'd5);
    pulse_req();
    chk(busy == 1'b1, "R9 busy after request", busy, 1);
    wait_enter(4'd0);
    chk(rx_cnt == base, "R4 nothing before wrap", rx_cnt - base, 0);
    while (rx_cnt < base + NB && idx != 4'd15 || rx_cnt < base + NB) begin
      if (!busy) dropped = 1;
      step();
    end
    chk(!dropped, "R9 busy held through packet", dropped, 0);
    chk(busy == 1'b1, "R9 busy at last stop bit", busy, 1);
    repeat (BIT_DIV - 1) step();
    chk(busy == 1'b1, "R9 busy before final pulse", busy, 1);
    step();
    chk(busy == 1'b0, "R9 busy low after final pulse", busy, 0);
    chk(rx_cnt - base == NB, "R4 byte count", rx_cnt - base, NB);
    check_packet(base, seed, "R2 R4 byte value in index order");
    chk(pos_err == pe, "R5 start bit position", pos_err - pe, 0);
    chk(stop_err == se, "R2 stop bit high", stop_err - se, 0);
  endtask

  task automatic t_back_to_back();
    int base;
    seed = 8'h3C; base = rx_cnt;
    wait_enter(4'd2);
    pulse_req();
    wait_enter(4'd0);
    wait_enter(4'd7);
    pulse_req();
    wait_enter(4'd0);
    chk(rx_cnt - base == NB, "R6 first packet complete", rx_cnt - base, NB);
    chk(busy == 1'b1, "R6 busy into second packet", busy, 1);
    wait_enter(4'd0);
    chk(rx_cnt - base == 2 * NB, "R6 second packet follows", rx_cnt - base, 2 * NB);
    check_packet(base + NB, seed, "R6 second packet bytes");
    wait_enter(4'd0);
    chk(rx_cnt - base == 2 * NB, "R6 no third packet", rx_cnt - base, 2 * NB);
  endtask

  task automatic t_coalesce();
    int base;
    seed = 8'h77; base = rx_cnt;
    wait_enter(4'd3); pulse_req();
    wait_enter(4'd5); pulse_req();
    wait_enter(4'd7); pulse_req();
    wait_enter(4'd0); wait_enter(4'd0);
    chk(rx_cnt - base == NB, "R7 one packet for many requests", rx_cnt - base, NB);
    check_packet(base, seed, "R7 packet bytes");
    wait_enter(4'd0);
    chk(rx_cnt - base == NB, "R7 no extra packet", rx_cnt - base, NB);
  endtask

  task automatic t_late();
    int base;
    seed = 8'h42; base = rx_cnt;
    wait_enter(4'd0);
    step(); step();
    pulse_req();
    wait_enter(4'd15);
    chk(rx_cnt == base && busy == 1'b1, "R8 waits a full scan", rx_cnt - base, 0);
    wait_enter(4'd0); wait_enter(4'd0);
    chk(rx_cnt - base == NB, "R8 packet after next wrap", rx_cnt - base, NB);
    check_packet(base, seed, "R8 packet bytes");
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) step();
    t_reset();
    t_idle();
    t_single();
    t_back_to_back();
    t_coalesce();
    t_late();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule